// File: doc/BRIEF.md
# Write Latency Monitor

This block is a passive observer for the write side of an AXI4 link between a processor and a fabric peripheral. It samples the handshake signals of the address, data and response channels but drives none of them. It reports the latency of every write transaction in system-clock cycles. A latency starts in the first cycle the address request is presented, whether or not the slave is ready. It ends in the first cycle the matching write response is presented.

Several writes may be in flight at once, and responses for different IDs may come back in any order. For this reason the monitor keeps a small FIFO of start timestamps for each ID. Each accepted response takes the oldest entry for its ID. Every accepted response produces a one-cycle report that carries the latency, the ID and the response code. The monitor also keeps a running minimum, maximum, total and count of completed writes, together with a count of accepted data beats, so that throughput can be derived. A synchronous clear input resets these figures. A sticky flag records a lost start, which happens when a FIFO is full, and a response that arrives with no start pending.

Top module: `wr_lat_mon`

## Requirements
- R1: A timestamp counter advances once per clock. Each reported latency equals the end timestamp minus the start timestamp, taken modulo 2^TS_W, so a counter wrap still yields the true cycle count.
- R2: The start of a write is the first cycle in which awvalid is high. While awvalid stays high without awready, no further start is recorded. If awvalid is still high in the cycle after an awvalid && awready handshake, that cycle starts a new write.
- R3: The end of a write is the first cycle in which bvalid is high for that response, even if bready delays acceptance.
- R4: lat_valid is high for exactly one cycle, the cycle after each bvalid && bready handshake for which a start is pending. In that cycle, lat_id and lat_resp carry the bid and bresp of that handshake. lat_valid is low at all other times.
- R5: Starts are matched to responses per ID. Responses for different IDs may arrive in any order. Responses for the same ID take that ID's starts oldest first.
- R6: On each report, done_count increments by one, lat_sum adds the latency, and lat_min and lat_max take the smaller and larger of their value and the latency.
- R7: beat_count increments once for every cycle in which wvalid && wready is high.
- R8: overflow becomes 1 and stays 1 in two cases. The first is a start for an ID whose FIFO already holds DEPTH entries; that start is dropped. The second is a response handshake for an ID with no pending start; that response produces no report and leaves the statistics unchanged.
- R9: A cycle with clear high sets lat_min to all ones, and sets lat_max, lat_sum, done_count, beat_count and overflow to zero. Clear takes priority over any update in the same cycle. Pending starts and the lat_valid report are not affected by clear.
- R10: After reset, lat_valid is 0, lat_min is all ones, and all other statistics and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous clear of statistics and overflow |
| awvalid | input | 1 | Observed write address valid |
| awready | input | 1 | Observed write address ready |
| awid | input | ID_W | Observed write address ID |
| wvalid | input | 1 | Observed write data valid |
| wready | input | 1 | Observed write data ready |
| bvalid | input | 1 | Observed write response valid |
| bready | input | 1 | Observed write response ready |
| bid | input | ID_W | Observed write response ID |
| bresp | input | 2 | Observed write response code |
| lat_valid | output | 1 | One-cycle report strobe |
| lat_cycles | output | TS_W | Reported latency in cycles |
| lat_id | output | ID_W | ID of the reported write |
| lat_resp | output | 2 | Response code of the reported write |
| lat_min | output | TS_W | Smallest latency since clear |
| lat_max | output | TS_W | Largest latency since clear |
| lat_sum | output | SUM_W | Total of latencies since clear |
| done_count | output | CNT_W | Completed writes since clear |
| beat_count | output | CNT_W | Accepted data beats since clear |
| overflow | output | 1 | Sticky lost-start or unmatched-response flag |

## Verification
On every cycle, the assertions check several properties. A report follows only a response handshake. Each report advances the completion count by exactly one, and data beats advance their count the same way. The minimum never exceeds the maximum once a write has completed. Overflow stays set until cleared, and clear zeroes the counters on the next cycle. Per-ID matching, out-of-order returns, the exact latency values (counter wrap, stalled address and stalled response phases included), FIFO-full and unmatched-response errors, and clear colliding with a handshake can only be shown by the bench's scenarios, which compare every output each cycle with a reference model.

// File: rtl/wr_lat_mon.sv
module wr_lat_mon #(
  parameter int ID_W  = 2,
  parameter int DEPTH = 4,
  parameter int TS_W  = 32,
  parameter int SUM_W = 48,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             awvalid,
  input  logic             awready,
  input  logic [ID_W-1:0]  awid,
  input  logic             wvalid,
  input  logic             wready,
  input  logic             bvalid,
  input  logic             bready,
  input  logic [ID_W-1:0]  bid,
  input  logic [1:0]       bresp,
  output logic             lat_valid,
  output logic [TS_W-1:0]  lat_cycles,
  output logic [ID_W-1:0]  lat_id,
  output logic [1:0]       lat_resp,
  output logic [TS_W-1:0]  lat_min,
  output logic [TS_W-1:0]  lat_max,
  output logic [SUM_W-1:0] lat_sum,
  output logic [CNT_W-1:0] done_count,
  output logic [CNT_W-1:0] beat_count,
  output logic             overflow
);
  localparam int NID   = 1 << ID_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [TS_W-1:0] ts, b_ts;
  logic            aw_open, b_wait;
  logic [TS_W-1:0] head [NID];
  logic [NID-1:0]  full_v, empty_v;

  wire start   = awvalid && !aw_open;
  wire push_ok = start && !full_v[awid];
  wire bhs     = bvalid && bready;
  wire pop_ok  = bhs && !empty_v[bid];
  wire lost    = (start && full_v[awid]) || (bhs && empty_v[bid]);

  wire [TS_W-1:0] end_ts  = b_wait ? b_ts : ts;
  wire [TS_W-1:0] lat_now = end_ts - head[bid];

  for (genvar g = 0; g < NID; g++) begin : g_id
    logic [TS_W-1:0]  slot [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CW-1:0]    cnt;
    wire psh = push_ok && (awid == ID_W'(g));
    wire pp  = pop_ok && (bid == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (psh) begin
          slot[wp] <= ts;
          wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
        end
        if (pp) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(psh) - CW'(pp);
      end
    end

    assign head[g]    = slot[rp];
    assign full_v[g]  = (cnt == CW'(DEPTH));
    assign empty_v[g] = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts      <= '0;
      b_ts    <= '0;
      aw_open <= 1'b0;
      b_wait  <= 1'b0;
    end else begin
      ts      <= ts + 1'b1;
      aw_open <= awvalid && !awready;
      b_wait  <= bvalid && !bready;
      if (bvalid && !b_wait) b_ts <= ts;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_valid  <= 1'b0;
      lat_cycles <= '0;
      lat_id     <= '0;
      lat_resp   <= '0;
    end else begin
      lat_valid <= pop_ok;
      if (pop_ok) begin
        lat_cycles <= lat_now;
        lat_id     <= bid;
        lat_resp   <= bresp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lat_min    <= '1;
      lat_max    <= '0;
      lat_sum    <= '0;
      done_count <= '0;
      beat_count <= '0;
      overflow   <= 1'b0;
    end else begin
      if (pop_ok) begin
        if (lat_now < lat_min) lat_min <= lat_now;
        if (lat_now > lat_max) lat_max <= lat_now;
        lat_sum    <= lat_sum + SUM_W'(lat_now);
        done_count <= done_count + 1'b1;
      end
      if (wvalid && wready) beat_count <= beat_count + 1'b1;
      if (lost) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/wr_lat_mon_chk.sv
module wr_lat_mon_chk #(
  parameter int TS_W  = 32,
  parameter int SUM_W = 48,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             wvalid,
  input logic             wready,
  input logic             bvalid,
  input logic             bready,
  input logic             lat_valid,
  input logic [TS_W-1:0]  lat_min,
  input logic [TS_W-1:0]  lat_max,
  input logic [SUM_W-1:0] lat_sum,
  input logic [CNT_W-1:0] done_count,
  input logic [CNT_W-1:0] beat_count,
  input logic             overflow
);
  p_report_after_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |-> $past(rst_n) && $past(bvalid && bready));

  p_done_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_valid && $past(rst_n) && !$past(clear)) |-> done_count == $past(done_count) + 1'b1);

  p_min_le_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_count != '0) |-> (lat_min <= lat_max));

  p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wvalid && wready) && !$past(clear)) |-> beat_count == $past(beat_count) + 1'b1);

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(overflow) && !$past(clear)) |-> overflow);

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clear)) |-> (done_count == '0 && beat_count == '0 && lat_sum == '0 && !overflow));
endmodule

bind wr_lat_mon wr_lat_mon_chk #(.TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/wr_lat_mon_bench.sv
module wr_lat_mon_bench;
  localparam int ID_W = 2, DEPTH = 4, TS_W = 8, SUM_W = 24, CNT_W = 16;
  localparam int NID = 1 << ID_W;
  localparam int unsigned MASK = (1 << TS_W) - 1;

  logic clk = 0, rst_n = 0, clear = 0;
  logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, bvalid = 0, bready = 0;
  logic [ID_W-1:0] awid = 0, bid = 0;
  logic [1:0] bresp = 0;
  logic lat_valid, overflow;
  logic [TS_W-1:0] lat_cycles, lat_min, lat_max;
  logic [ID_W-1:0] lat_id;
  logic [1:0] lat_resp;
  logic [SUM_W-1:0] lat_sum;
  logic [CNT_W-1:0] done_count, beat_count;

  always #5 clk = ~clk;

  wr_lat_mon #(.ID_W(ID_W), .DEPTH(DEPTH), .TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_wr_lat_mon (.*);

  int n_checks = 0, n_fail = 0;
  int unsigned tcur = 0, b_ts_m = 0;
  bit aw_open_m = 0, b_wait_m = 0;
  int unsigned q [NID][DEPTH];
  int qn [NID];
  bit e_valid = 0, e_ovf = 0;
  int unsigned e_lat = 0, e_id = 0, e_resp = 0, e_min = MASK, e_max = 0, e_sum = 0, e_done = 0, e_beats = 0;

  function automatic int unsigned span(int unsigned s, int unsigned e);
    return (e - s) & MASK;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R4 lat_valid", lat_valid, e_valid);
    if (e_valid) begin
      chk("R1 lat_cycles", lat_cycles, e_lat);
      chk("R5 lat_id", lat_id, e_id);
      chk("R4 lat_resp", lat_resp, e_resp);
    end
    chk("R6 lat_min", lat_min, e_min);
    chk("R6 lat_max", lat_max, e_max);
    chk("R6 lat_sum", lat_sum, e_sum);
    chk("R6 done_count", done_count, e_done);
    chk("R7 beat_count", beat_count, e_beats);
    chk("R8 overflow", overflow, e_ovf);
  endtask

  task automatic model_step();
    bit start, bhs, full_a, pop_ok;
    int unsigned l;
    start  = awvalid && !aw_open_m;
    bhs    = bvalid && bready;
    full_a = (qn[awid] == DEPTH);
    pop_ok = bhs && (qn[bid] > 0);
    e_valid = pop_ok;
    l = 0;
    if (pop_ok) begin
      l = span(q[bid][0], b_wait_m ? b_ts_m : tcur);
      e_lat = l; e_id = bid; e_resp = bresp;
    end
    if (clear) begin
      e_min = MASK; e_max = 0; e_sum = 0; e_done = 0; e_beats = 0; e_ovf = 0;
    end else begin
      if (pop_ok) begin
        if (l < e_min) e_min = l;
        if (l > e_max) e_max = l;
        e_sum = (e_sum + l) & ((1 << SUM_W) - 1);
        e_done++;
      end
      if (wvalid && wready) e_beats++;
      if ((start && full_a) || (bhs && !pop_ok)) e_ovf = 1;
    end
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) q[bid][i] = q[bid][i+1];
      qn[bid]--;
    end
    if (start && !full_a) begin
      q[awid][qn[awid]] = tcur & MASK;
      qn[awid]++;
    end
    aw_open_m = awvalid && !awready;
    if (bvalid && !b_wait_m) b_ts_m = tcur & MASK;
    b_wait_m = bvalid && !bready;
    tcur++;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(int n);
    awvalid = 0; awready = 0; wvalid = 0; wready = 0; bvalid = 0; bready = 0; clear = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic one_aw(int id);
    awvalid = 1; awready = 1; awid = id[ID_W-1:0]; tick(); awvalid = 0; awready = 0;
  endtask

  task automatic one_b(int id, int r);
    bvalid = 1; bready = 1; bid = id[ID_W-1:0]; bresp = r[1:0]; tick(); bvalid = 0; bready = 0;
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NID; i++) qn[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tcur = 0;
    chk("R10 lat_valid", lat_valid, 0);
    chk("R10 lat_min", lat_min, MASK);
    chk("R10 done_count", done_count, 0);
    chk("R10 overflow", overflow, 0);
    idle(2);

    // stalled address then stalled response: latency 10
    awvalid = 1; awid = 1; awready = 0;
    repeat (3) tick();
    awready = 1; tick();
    idle(6);
    bvalid = 1; bid = 1; bready = 0; bresp = 2;
    repeat (2) tick();
    bready = 1; tick();
    chk("R3 stalled latency", lat_cycles, 10);
    chk("R3 report strobe", lat_valid, 1);
    bvalid = 0; bready = 0; tick();
    chk("R4 single pulse", lat_valid, 0);
    one_b(1, 0);
    chk("R2 held awvalid made one start", overflow, 1);
    chk("R8 unmatched no report", lat_valid, 0);
    clear = 1; tick(); clear = 0;
    chk("R9 overflow cleared", overflow, 0);
    chk("R9 min reset", lat_min, MASK);

    // back-to-back handshakes: awvalid kept high makes a new start each cycle
    awvalid = 1; awready = 1; awid = 0; repeat (2) tick();
    awvalid = 0; awready = 0;
    one_aw(2);
    idle(3);
    one_b(2, 1);
    chk("R5 out of order id", lat_id, 2);
    one_b(0, 0);
    one_b(0, 3);
    chk("R2 second start matched", done_count, 3);

    // fill one FIFO past its depth
    for (int i = 0; i <= DEPTH; i++) one_aw(3);
    chk("R8 full fifo overflow", overflow, 1);
    for (int i = 0; i < DEPTH; i++) one_b(3, 0);
    chk("R8 drained reports", done_count, 3 + DEPTH);

    // clear colliding with a response handshake
    one_aw(0);
    idle(2);
    clear = 1; bvalid = 1; bready = 1; bid = 0; tick();
    clear = 0; bvalid = 0; bready = 0;
    chk("R9 clear wins", done_count, 0);
    chk("R9 report kept", lat_valid, 1);

    // constrained random traffic, counter wraps many times
    for (int c = 0; c < 6000; c++) begin
      if (!aw_open_m) begin
        awid = ID_W'($urandom % NID);
        awvalid = ($urandom % 3 == 0) && (qn[awid] < DEPTH);
      end
      awready = $urandom % 2;
      wvalid = $urandom % 2;
      wready = $urandom % 2;
      if (!b_wait_m) begin
        bid = ID_W'($urandom % NID);
        bresp = 2'($urandom % 4);
        bvalid = ($urandom % 3 == 0) && (qn[bid] > 0);
      end
      bready = $urandom % 2;
      clear = ($urandom % 97 == 0);
      tick();
    end
    idle(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule